// File: doc/BRIEF.md
# Free-Running 64-bit Timer with Compare and Periodic Reload

This block is a memory-mapped timer. It has a 64-bit counter that runs on a divided clock and a 64-bit comparator. A sticky event flag is raised when the counter has reached or passed the comparator. Software programs it through a single-cycle 32-bit register port. The port has an address, a write strobe, write data and combinational read data. The counter and the comparator are each reached as two 32-bit halves.

The flag drives a level interrupt line through an enable bit. For periodic events, an auto-increment mode adds a programmed step to the comparator each time an event fires, so the next event comes that many counter ticks later.

To read the full count, software reads the high half, then the low half, then the high half again, and repeats if the two high reads differ. To move the comparator safely, software clears the compare enable, writes both halves, and then enables compare again.

Top module: `gtmr_top`

## Requirements
- R1: After reset every mapped register (counter halves at 0x00/0x04, control at 0x08, status at 0x0C, comparator halves at 0x10/0x14, step at 0x18) reads zero, and irq_o is low.
- R2: Control bit 0 is the run bit. While it is set, the counter increments once every P+1 clocks, where P is control bits [15:8]; the first increment comes P+1 clocks after the write that sets the run bit. While the run bit is clear, the counter holds its value.
- R3: Writes to offset 0x00 load the low 32 bits of the counter and writes to 0x04 load the high 32 bits. A tick that overflows the low half carries into the high half on the same clock, so the two halves are always consistent with each other.
- R4: Control reads back bits 0 to 3 and [15:8] as written, and all other bits as zero. Any offset other than the seven mapped ones reads zero.
- R5: While control bit 1 (compare enable) is set, status bit 0 (the event flag) is set on the clock after the 64-bit counter is greater than or equal to the 64-bit comparator. This includes a counter that is already past the comparator. Both halves take part in the comparison.
- R6: While compare enable is clear, the event flag is never set, whatever the counter and comparator values are.
- R7: Writing a 1 to status bit 0 clears the flag. Writing a 0 there leaves it unchanged.
- R8: If a compare hit and a clear write land on the same clock, the flag stays set.
- R9: While control bit 3 (auto-increment) is set, each clock with a compare hit adds the 32-bit step at 0x18 to the comparator. While it is clear, the comparator is never changed by hardware.
- R10: irq_o is high exactly when the event flag is set and control bit 2 (interrupt enable) is set. It stays high until the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW (8) | Register byte offset |
| we_i | input | 1 | Write strobe, one clock per write |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets four places where the block is easy to get wrong:
- **Carry across the halves.** It starts the counter just below a 32-bit boundary. A design that delays the carry into the high half would show a torn value for one clock.
- **Compare that only tests equality, or only the low half.** It loads a counter that is already past the comparator, and a pair that differs only in the high half. A design with these faults would either never fire or fire early.
- **Set against clear on the same clock.** It writes the clear while a hit is still present. A design with the wrong priority would lose the event.
- **Periodic reload.** It follows the comparator clock by clock against a model built from the requirements. An off-by-one in the timing of the increment, or an increment made while compare is disabled, would show up as a wrong comparator value.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int PSC_W = 8;
  localparam int OFS_CNT_LO = 'h00;
  localparam int OFS_CNT_HI = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_STAT   = 'h0C;
  localparam int OFS_CMP_LO = 'h10;
  localparam int OFS_CMP_HI = 'h14;
  localparam int OFS_STEP   = 'h18;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             ainc;
    logic             irq_en;
    logic             cmp_en;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  // >= keeps a shrinking divider from wrapping the full range
  assign tick_o = run_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || tick_o)  div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_i != '0 && run_i) |=> (!tick_o || psc_i != $past(psc_i)));
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [1:0]      wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [2*DW-1:0] cnt_o
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  // full-width add: carry reaches the high half on the same tick
  assign cnt_inc = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (wr_i[h])     cnt_q[h*DW +: DW] <= wdata_i;
        else if (tick_i) cnt_q[h*DW +: DW] <= cnt_inc[h*DW +: DW];
      end
    end
  end

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wr_i == 2'b00) |=> cnt_q == $past(cnt_q) + 64'd1);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && wr_i == 2'b00) |=> $stable(cnt_q));
  assert_lo_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i[0] |=> cnt_q[DW-1:0] == $past(wdata_i));
endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            cmp_en_i,
  input  logic            ainc_i,
  input  logic [1:0]      wr_i,
  input  logic            step_wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            clr_i,
  output logic [2*DW-1:0] cmp_o,
  output logic [DW-1:0]   step_o,
  output logic            flag_o
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cmp_q;
  logic [DW-1:0] step_q;
  logic [CW-1:0] step_ext;
  logic [CW-1:0] cmp_nxt;
  logic          flag_q;
  logic          hit;

  assign hit      = cmp_en_i && (cnt_i >= cmp_q);
  assign step_ext = {{DW{1'b0}}, step_q};
  assign cmp_nxt  = cmp_q + step_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (wr_i[h])            cmp_q[h*DW +: DW] <= wdata_i;
        else if (hit && ainc_i) cmp_q[h*DW +: DW] <= cmp_nxt[h*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        step_q <= '0;
    else if (step_wr_i) step_q <= wdata_i;
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign cmp_o  = cmp_q;
  assign step_o = step_q;
  assign flag_o = flag_q;

  assert_hit_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q);
  assert_off_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_en_i && !flag_q) |=> !flag_q);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_q);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit) |=> flag_q);
  assert_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && ainc_i && wr_i == 2'b00) |=> cmp_q == $past(cmp_q) + $past(step_ext));
  assert_no_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ainc_i && wr_i == 2'b00) |=> $stable(cmp_q));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  import gtmr_pkg::*;

  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] A_CNT_LO = AW'(OFS_CNT_LO);
  localparam logic [AW-1:0] A_CNT_HI = AW'(OFS_CNT_HI);
  localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_STAT   = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CMP_LO = AW'(OFS_CMP_LO);
  localparam logic [AW-1:0] A_CMP_HI = AW'(OFS_CMP_HI);
  localparam logic [AW-1:0] A_STEP   = AW'(OFS_STEP);

  ctrl_t         ctrl_q;
  logic          tick;
  logic [1:0]    cnt_wr;
  logic [1:0]    cmp_wr;
  logic          step_wr;
  logic          clr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cmp;
  logic [DW-1:0] step;
  logic          flag;
  logic [DW-1:0] ctrl_rd;

  assign cnt_wr  = {we_i && addr_i == A_CNT_HI, we_i && addr_i == A_CNT_LO};
  assign cmp_wr  = {we_i && addr_i == A_CMP_HI, we_i && addr_i == A_CMP_LO};
  assign step_wr = we_i && addr_i == A_STEP;
  assign clr     = we_i && addr_i == A_STAT && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i && addr_i == A_CTRL) begin
      ctrl_q.run    <= wdata_i[0];
      ctrl_q.cmp_en <= wdata_i[1];
      ctrl_q.irq_en <= wdata_i[2];
      ctrl_q.ainc   <= wdata_i[3];
      ctrl_q.psc    <= wdata_i[8 +: PSC_W];
    end
  end

  gtmr_prescale #(.PSC_W(PSC_W)) u_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .psc_i  (ctrl_q.psc),
    .tick_o (tick)
  );

  gtmr_counter #(.DW(DW)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  gtmr_compare #(.DW(DW)) u_compare (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .cmp_en_i  (ctrl_q.cmp_en),
    .ainc_i    (ctrl_q.ainc),
    .wr_i      (cmp_wr),
    .step_wr_i (step_wr),
    .wdata_i   (wdata_i),
    .clr_i     (clr),
    .cmp_o     (cmp),
    .step_o    (step),
    .flag_o    (flag)
  );

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[0]          = ctrl_q.run;
    ctrl_rd[1]          = ctrl_q.cmp_en;
    ctrl_rd[2]          = ctrl_q.irq_en;
    ctrl_rd[3]          = ctrl_q.ainc;
    ctrl_rd[8 +: PSC_W] = ctrl_q.psc;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CNT_LO: rdata_o = cnt[DW-1:0];
      A_CNT_HI: rdata_o = cnt[CW-1:DW];
      A_CTRL:   rdata_o = ctrl_rd;
      A_STAT:   rdata_o[0] = flag;
      A_CMP_LO: rdata_o = cmp[DW-1:0];
      A_CMP_HI: rdata_o = cmp[CW-1:DW];
      A_STEP:   rdata_o = step;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = flag & ctrl_q.irq_en;

  assert_irq_needs_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> flag);
  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && !wdata_i[2]) |=> !irq_o);
endmodule

// File: tb/gtmr_top_tb.sv
`timescale 1ns/1ps
module gtmr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gtmr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd64(input logic [7:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 8'h04, hi); d = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    logic [63:0] w;
    int unsigned seed;
    seed = $urandom(32'd4711);
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    for (int a = 0; a <= 'h18; a += 4) begin rd(8'(a), v); chk("R1 reset read", v, 0); end
    chk("R1 irq after reset", irq, 0);

    // R4 control mask and unmapped offsets
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R4 ctrl readback", v, 32'h0000_FF0F);
    wr(8'h08, 0);
    wr(8'h18, 32'hABCD_1234);
    rd(8'h1C, v); chk("R4 unmapped 0x1C", v, 0);
    rd(8'h19, v); chk("R4 unmapped 0x19", v, 0);
    rd(8'h40, v); chk("R4 unmapped 0x40", v, 0);

    // R2 counting with several dividers
    for (int t = 0; t < 3; t++) begin
      int p;
      p = (t == 0) ? 0 : (t == 1) ? 3 : int'($urandom_range(1, 7));
      wr(8'h08, 0); wr(8'h00, 0); wr(8'h04, 0);
      wr(8'h08, (p << 8) | 1);
      rd(8'h00, v); chk("R2 start", v, 0);
      for (int k = 1; k <= 20; k++) begin
        idle(1); rd(8'h00, v); chk("R2 rate", v, 32'(k / (p + 1)));
      end
      wr(8'h08, 0); rd(8'h00, v); idle(5); rd(8'h00, v2);
      chk("R2 hold when stopped", v2, v);
    end

    // R3 carry between halves
    for (int t = 0; t < 4; t++) begin
      logic [63:0] base;
      base = (t == 3) ? 64'hFFFF_FFFF_FFFF_FFFE
                      : {$urandom(), 32'hFFFF_FFFF - 32'($urandom_range(0, 2))};
      wr(8'h08, 0); wr(8'h00, base[31:0]); wr(8'h04, base[63:32]);
      wr(8'h08, 1);
      for (int k = 0; k < 5; k++) begin
        rd64(8'h00, w); chk("R3 carry", w, base + 64'(k)); idle(1);
      end
    end

    // R6 compare disabled, R5 greater-or-equal
    wr(8'h08, 0); wr(8'h0C, 1);
    wr(8'h00, 100); wr(8'h04, 0); wr(8'h10, 50); wr(8'h14, 0);
    idle(3); rd(8'h0C, v); chk("R6 no flag when compare off", v, 0);
    wr(8'h08, 2); rd(8'h0C, v); chk("R5 flag one clock later", v, 0);
    idle(1); rd(8'h0C, v); chk("R5 counter past comparator", v, 1);

    // R5 high half matters
    wr(8'h08, 0); wr(8'h0C, 1);
    wr(8'h10, 0); wr(8'h14, 1); wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 0);
    wr(8'h08, 2); idle(2); rd(8'h0C, v); chk("R5 high half below", v, 0);
    wr(8'h08, 3); idle(2); rd(8'h0C, v); chk("R5 high half reached", v, 1);

    // R8 set wins, R7 clear semantics
    wr(8'h08, 2);
    wr(8'h0C, 1); rd(8'h0C, v); chk("R8 hit beats clear", v, 1);
    wr(8'h08, 0);
    wr(8'h0C, 32'hFFFF_FFFE); rd(8'h0C, v); chk("R7 zero write ignored", v, 1);
    wr(8'h0C, 1); rd(8'h0C, v); chk("R7 one clears", v, 0);

    // R10 exact event timing on irq_o
    begin
      int kk;
      kk = int'($urandom_range(2, 30));
      wr(8'h00, 0); wr(8'h04, 0); wr(8'h10, 32'(kk)); wr(8'h14, 0); wr(8'h0C, 1);
      wr(8'h08, 7);
      chk("R10 irq idle", irq, 0);
      for (int k = 1; k <= kk + 3; k++) begin
        idle(1); chk("R10 irq timing", irq, (k >= kk + 1) ? 1 : 0);
      end
      rd(8'h10, v); chk("R9 no reload when off", v, 32'(kk));
      wr(8'h08, 3); chk("R10 irq masked", irq, 0);
      rd(8'h0C, v); chk("R10 flag kept while masked", v, 1);
      wr(8'h08, 7); chk("R10 irq unmasked", irq, 1);
    end

    // R9 periodic reload against a model
    begin
      int kk, ss, m;
      longint c;
      kk = int'($urandom_range(3, 20));
      ss = int'($urandom_range(3, 10));
      m = kk + 4 * ss + 3;
      wr(8'h08, 0); wr(8'h00, 0); wr(8'h04, 0);
      wr(8'h10, 32'(kk)); wr(8'h14, 0); wr(8'h18, 32'(ss)); wr(8'h0C, 1);
      wr(8'h08, 32'hF);
      c = kk;
      for (int j = 1; j <= m; j++) begin
        idle(1);
        if (longint'(j - 1) >= c) c += ss;
        rd64(8'h10, w); chk("R9 comparator reload", w, 64'(c));
      end
      rd(8'h0C, v); chk("R9 flag after reload", v, 1);
    end

    // R1 asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 irq in reset", irq, 0);
    rd(8'h00, v); chk("R1 counter in reset", v, 0);
    rd(8'h08, v); chk("R1 ctrl in reset", v, 0);
    rd(8'h10, v); chk("R1 comparator in reset", v, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule